// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a byte-wide memory that a host reaches over a two-wire open-drain bus. It watches the clock and data lines from inside a system clock domain. It recognises start and stop conditions and answers a device-select byte whose two low address bits match a pair of strap inputs. After that it runs a write sequence (two address bytes, then one or more data bytes) or a read sequence (bytes streamed out from an address counter). The block never drives the data line high. It only asserts a pull-low enable, and the pad or the bench turns that into the wired-AND line.

Data bytes from the host first go into a one-page holding buffer. They are copied into the storage array only after a stop, during a self-timed write cycle of a set number of system clocks. For that whole cycle the target acknowledges nothing, so a host can poll it until it answers. A write-protect input that is high at the stop cancels the copy. The storage is a plain register array whose size is set by a parameter.

Top module: `eeprom_twi_target`

## Requirements
- R1: After reset the pull-low output is low and busy is low. A falling data line while the clock is high (start) always restarts reception of a device-select byte. A rising data line while the clock is high (stop) always returns the target to idle.
- R2: Incoming bits are taken on clock rising edges, most significant bit first. The pull-low output changes only while the synchronised clock is low. Each accepted byte is acknowledged by pulling the line low through the ninth clock.
- R3: The device-select byte is bits 7..4 = 1010, bit 3 = 0, bits 2..1 = strap_i, and bit 0 = direction (1 read, 0 write). On any mismatch the target does not acknowledge, and it ignores the bus until the next start.
- R4: A write-select byte is followed by a high and a low address byte, each acknowledged. The location is the low ADDR_W bits of the 16-bit value {high, low}; higher bits are ignored (default ADDR_W = 10, 1024 locations).
- R5: Each data byte of a write goes to the current address, after which only the low 6 address bits step and the upper bits stay fixed. A byte past the end of a 64-byte page wraps to the start of the same page, and a later byte overwrites an earlier one.
- R6: A stop that follows at least one data byte starts a write cycle of WR_CYCLES system clocks, with busy high throughout. While busy the target acknowledges no byte, its own device-select byte included. It acknowledges again once busy falls.
- R7: If wp_i is high when the stop arrives, no location changes and no write cycle starts.
- R8: An address counter holds the location after the last one read or written and keeps it between transactions. A read-select byte right after a start returns the byte at that counter.
- R9: A write-select byte, two address bytes, a repeated start and a read-select byte return the byte at the loaded address.
- R10: During a read the target sends the next location each time the host acknowledges, wrapping from the last location to location 0. A missing host acknowledge ends the read.
- R11: Data bytes reach the array only at a stop. A start that arrives in place of the stop discards them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| strap_i | input | 2 | Board-strapped device address bits |
| wp_i | input | 1 | Write protect, high blocks the commit |
| sda_pull_o | output | 1 | Pull data line low when high |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
The assertions assume that the bus clock is slow compared to the system clock. Each clock phase lasts well over three system cycles, so every line change is seen after synchronisation before the next one arrives. They also assume that the host never sends a stop while the target holds the line low. The stimulus meets both. It bit-bangs the bus with five system clocks per quarter bit, and it changes the data line only a quarter bit after the clock falls. The host releases the line for every bit the target may drive, and it issues stops only after the target has let go. Random addresses, lengths and data run alongside directed cases for page wrap, array wrap, strap mismatch, write protect, discard and polling.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } eep_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } eep_kind_e;

    localparam logic [4:0] DEV_TAG = 5'b10100;

endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_p;
        logic              sda_p;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d        = mon_q;
        mon_d.scl_ff = {mon_q.scl_ff[STAGES-2:0], scl_i};
        mon_d.sda_ff = {mon_q.sda_ff[STAGES-2:0], sda_i};
        mon_d.scl_p  = mon_q.scl_ff[STAGES-1];
        mon_d.sda_p  = mon_q.sda_ff[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '1;
        else        mon_q <= mon_d;
    end

    assign scl_s     = mon_q.scl_ff[STAGES-1];
    assign sda_s     = mon_q.sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~mon_q.scl_p;
    assign scl_fall  = ~scl_s & mon_q.scl_p;
    assign start_det = scl_s & mon_q.scl_p & mon_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & mon_q.scl_p & ~mon_q.sda_p & sda_s;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 600
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     commit_go,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PB    = 1 << PAGE_W;
    localparam int RUN   = (WR_CYCLES > PB) ? WR_CYCLES : PB;
    localparam int TW    = $clog2(RUN + 1);

    typedef struct packed {
        logic [TW-1:0]              timer;
        logic [PAGE_W:0]            cidx;
        logic [ADDR_W-PAGE_W-1:0]   page;
        logic [PB-1:0]              valid;
    } st_t;

    st_t st_d, st_q;

    logic [7:0]        pbuf [PB];
    logic [7:0]        mem  [DEPTH];
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;

    always_comb begin
        st_d = st_q;
        if (commit_go && st_q.timer == '0) begin
            st_d.timer = TW'(RUN);
            st_d.cidx  = '0;
            st_d.page  = commit_page;
        end else if (st_q.timer != '0) begin
            st_d.timer = st_q.timer - 1'b1;
            if (!st_q.cidx[PAGE_W]) st_d.cidx = st_q.cidx + 1'b1;
        end
        if (buf_clr)     st_d.valid = '0;
        else if (buf_we) st_d.valid[buf_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we   = (st_q.timer != '0) && !st_q.cidx[PAGE_W] && st_q.valid[st_q.cidx[PAGE_W-1:0]];
    assign mem_addr = {st_q.page, st_q.cidx[PAGE_W-1:0]};

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= pbuf[st_q.cidx[PAGE_W-1:0]];
    end

    assign rd_data = mem[rd_addr];
    assign busy    = st_q.timer != '0;

    // R6: a commit request always opens a write cycle
    assert_busy_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> busy);

    // R6: nothing enters the page buffer while the write cycle runs
    assert_no_fill_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !busy);

endmodule

// File: rtl/eeprom_twi_target.sv
module eeprom_twi_target
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o,
    output logic       busy_o
);
    typedef struct packed {
        eep_state_e        st;
        eep_kind_e         kind;
        logic [3:0]        bitcnt;
        logic [7:0]        sh;
        logic              pull;
        logic              rd;
        logic [7:0]        ahi;
        logic [ADDR_W-1:0] ptr;
        logic              seen;
        logic              hack;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic buf_clr, buf_we, commit_go, busy, dev_match;
    logic [7:0] rd_data;

    eep_line_mon #(.STAGES(2)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_clr     (buf_clr),
        .buf_we      (buf_we),
        .buf_idx     (fsm_q.ptr[PAGE_W-1:0]),
        .buf_data    (fsm_q.sh),
        .commit_go   (commit_go),
        .commit_page (fsm_q.ptr[ADDR_W-1:PAGE_W]),
        .rd_addr     (fsm_q.ptr),
        .rd_data     (rd_data),
        .busy        (busy)
    );

    assign dev_match = (fsm_q.sh[7:3] == DEV_TAG) && (fsm_q.sh[2:1] == strap_i) && !busy;

    always_comb begin
        fsm_d     = fsm_q;
        buf_clr   = 1'b0;
        buf_we    = 1'b0;
        commit_go = 1'b0;
        if (stop_det) begin
            commit_go   = fsm_q.seen && !wp_i && !busy;
            fsm_d.st    = ST_IDLE;
            fsm_d.pull  = 1'b0;
            fsm_d.seen  = 1'b0;
        end else if (start_det) begin
            fsm_d.st     = ST_RX;
            fsm_d.kind   = K_DEV;
            fsm_d.bitcnt = '0;
            fsm_d.pull   = 1'b0;
            fsm_d.seen   = 1'b0;
        end else begin
            case (fsm_q.st)
                ST_RX: begin
                    if (scl_rise && fsm_q.bitcnt != 4'd8) begin
                        fsm_d.sh     = {fsm_q.sh[6:0], sda_s};
                        fsm_d.bitcnt = fsm_q.bitcnt + 4'd1;
                    end else if (scl_fall && fsm_q.bitcnt == 4'd8) begin
                        fsm_d.st   = ST_ACK;
                        fsm_d.pull = 1'b1;
                        case (fsm_q.kind)
                            K_DEV: begin
                                if (dev_match) begin
                                    fsm_d.rd   = fsm_q.sh[0];
                                    fsm_d.kind = K_AHI;
                                    buf_clr    = !fsm_q.sh[0];
                                end else begin
                                    fsm_d.st   = ST_IDLE;
                                    fsm_d.pull = 1'b0;
                                end
                            end
                            K_AHI: begin
                                fsm_d.ahi  = fsm_q.sh;
                                fsm_d.kind = K_ALO;
                            end
                            K_ALO: begin
                                fsm_d.ptr  = ADDR_W'({fsm_q.ahi, fsm_q.sh});
                                fsm_d.kind = K_DATA;
                            end
                            default: begin
                                buf_we     = 1'b1;
                                fsm_d.seen = 1'b1;
                                fsm_d.ptr  = {fsm_q.ptr[ADDR_W-1:PAGE_W], fsm_q.ptr[PAGE_W-1:0] + 1'b1};
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        fsm_d.bitcnt = '0;
                        if (fsm_q.rd) begin
                            fsm_d.st   = ST_TX;
                            fsm_d.sh   = rd_data;
                            fsm_d.pull = ~rd_data[7];
                        end else begin
                            fsm_d.st   = ST_RX;
                            fsm_d.pull = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (fsm_q.bitcnt == 4'd7) begin
                            fsm_d.pull = 1'b0;
                            fsm_d.st   = ST_RACK;
                            fsm_d.ptr  = fsm_q.ptr + 1'b1;
                        end else begin
                            fsm_d.sh     = {fsm_q.sh[6:0], 1'b0};
                            fsm_d.pull   = ~fsm_q.sh[6];
                            fsm_d.bitcnt = fsm_q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        fsm_d.hack = ~sda_s;
                    end else if (scl_fall) begin
                        if (fsm_q.hack) begin
                            fsm_d.st     = ST_TX;
                            fsm_d.bitcnt = '0;
                            fsm_d.sh     = rd_data;
                            fsm_d.pull   = ~rd_data[7];
                        end else begin
                            fsm_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q      <= '0;
            fsm_q.st   <= ST_IDLE;
            fsm_q.kind <= K_DEV;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_pull_o = fsm_q.pull;
    assign busy_o     = busy;

    // R2: the target only starts pulling the line while the clock is low
    assert_drive_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);

    // R6: the line stays released for the whole write cycle
    assert_silent_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_pull_o);

    // R7: a write cycle never opens while write protect was high
    assert_wp_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(wp_i) == 1'b0));

    // R1: a stop leaves the line released on the next cycle
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

endmodule

// File: tb/sim_eeprom_twi_target.sv
module sim_eeprom_twi_target;
    localparam int Q     = 5;
    localparam int AW    = 10;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_sda = 1'b1;
    logic wp = 1'b0;
    logic pull, busy;
    logic bus;

    int errors = 0;
    int checks = 0;
    int glitch = 0;

    logic [7:0]    model [1 << AW];
    logic [AW-1:0] mptr;
    logic [7:0]    wdat [80];
    logic [7:0]    rdat [80];

    always #10 clk = ~clk;
    assign bus = host_sda & ~pull;

    eeprom_twi_target u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (bus),
        .strap_i    (STRAP),
        .wp_i       (wp),
        .sda_pull_o (pull),
        .busy_o     (busy)
    );

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1010, 1'b0, STRAP, rd};
    endfunction

    function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a, input int i);
        logic [5:0] lo = a[5:0] + 6'(i);
        return {a[AW-1:6], lo};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    // R2 monitor: the pull output may only move while the bus clock is low
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && pull != pull_prev) glitch++;
        pull_prev = pull;
    end

    task automatic bus_start;
        host_sda = 1'b1; qw(1);
        scl = 1'b1;      qw(1);
        host_sda = 1'b0; qw(1);
        scl = 1'b0;      qw(1);
    endtask

    task automatic bus_stop;
        host_sda = 1'b0; qw(1);
        scl = 1'b1;      qw(1);
        host_sda = 1'b1; qw(2);
    endtask

    task automatic put_bit(input logic b);
        qw(1); host_sda = b;
        qw(1); scl = 1'b1;
        qw(2); scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        qw(1); host_sda = 1'b1;
        qw(1); scl = 1'b1;
        qw(1); b = bus;
        qw(1); scl = 1'b0;
    endtask

    task automatic send(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv(input bit ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!ack);
    endtask

    task automatic tx_write(input logic [14:0] addr, input int n, output bit ok);
        bit a;
        logic [AW-1:0] base = addr[AW-1:0];
        ok = 1'b1;
        bus_start;
        send(dev(1'b0), a);        ok &= a;
        send({1'b0, addr[14:8]}, a); ok &= a;
        send(addr[7:0], a);        ok &= a;
        for (int i = 0; i < n; i++) begin
            send(wdat[i], a);
            ok &= a;
        end
        bus_stop;
        if (!wp) for (int i = 0; i < n; i++) model[page_step(base, i)] = wdat[i];
        mptr = page_step(base, n);
    endtask

    task automatic wait_ready(output int polls);
        bit a;
        polls = 0;
        do begin
            bus_start;
            send(dev(1'b0), a);
            bus_stop;
            polls++;
        end while (!a && polls < 200);
    endtask

    task automatic rd_bytes(input int n);
        for (int i = 0; i < n; i++) recv(i < n - 1, rdat[i]);
        bus_stop;
        mptr = mptr + AW'(n);
    endtask

    task automatic rd_random(input logic [14:0] addr, input int n, output bit ok);
        bit a;
        ok = 1'b1;
        bus_start;
        send(dev(1'b0), a);          ok &= a;
        send({1'b0, addr[14:8]}, a); ok &= a;
        send(addr[7:0], a);          ok &= a;
        bus_start;
        send(dev(1'b1), a);          ok &= a;
        mptr = addr[AW-1:0];
        rd_bytes(n);
    endtask

    task automatic rd_current(input int n, output bit ok);
        bit a;
        bus_start;
        send(dev(1'b1), a);
        ok = a;
        rd_bytes(n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok, a;
        int polls;
        logic [AW-1:0] ea;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1 pull after reset", pull, 0);
        chk("R1 busy after reset", busy, 0);

        // R3: wrong strap and wrong fixed bit get no acknowledge
        bus_start;
        send({4'b1010, 1'b0, ~STRAP, 1'b0}, a);
        chk("R3 strap mismatch nack", a, 0);
        send(8'h00, a);
        chk("R3 ignored until start", a, 0);
        bus_stop;
        bus_start;
        send({4'b1010, 1'b1, STRAP, 1'b0}, a);
        chk("R3 fixed bit mismatch nack", a, 0);
        bus_stop;

        // R4/R6: page write of 8 bytes, upper address bits ignored
        for (int i = 0; i < 8; i++) wdat[i] = 8'h30 + 8'(i);
        tx_write(15'h5120, 8, ok);
        chk("R4 address and data acked", ok, 1);
        qw(1);
        chk("R6 busy after stop", busy, 1);
        bus_start;
        send(dev(1'b0), a);
        chk("R6 no ack while busy", a, 0);
        bus_stop;
        wait_ready(polls);
        chk("R6 ack again after cycle", polls > 1 && polls < 200, 1);
        chk("R6 busy dropped", busy, 0);

        // R9 random read, R8 current address read
        rd_random(15'h0123, 1, ok);
        chk("R9 random read value", rdat[0], model[10'h123]);
        rd_current(1, ok);
        chk("R8 current read ack", ok, 1);
        chk("R8 current read value", rdat[0], model[10'h124]);

        // R5 page wrap with overwrite, R10 sequential read of the page
        for (int i = 0; i < 70; i++) wdat[i] = 8'(8'hA0 ^ (i * 7));
        tx_write(15'h01FA, 70, ok);
        wait_ready(polls);
        rd_random(15'h01C0, 64, ok);
        for (int i = 0; i < 64; i++) chk("R5 page wrap contents", rdat[i], model[10'h1C0 + i]);
        chk("R5 overwrite kept last", model[10'h1FA], wdat[64]);
        chk("R10 sequential ack stream", ok, 1);

        // R7 write protect
        wp = 1'b1;
        wdat[0] = 8'h5A;
        tx_write(15'h0123, 1, ok);
        qw(1);
        chk("R7 no cycle when protected", busy, 0);
        wp = 1'b0;
        rd_random(15'h0123, 1, ok);
        chk("R7 location unchanged", rdat[0], model[10'h123]);

        // R11 start in place of stop discards data
        bus_start;
        send(dev(1'b0), a);
        send(8'h01, a);
        send(8'h23, a);
        send(8'hEE, a);
        bus_start;
        send(dev(1'b0), a);
        bus_stop;
        qw(1);
        chk("R11 no cycle after discard", busy, 0);
        rd_random(15'h0123, 1, ok);
        chk("R11 discarded data absent", rdat[0], model[10'h123]);

        // R10 array wrap from last location to zero
        wdat[0] = 8'hC3;
        tx_write(15'h03FF, 1, ok);
        wait_ready(polls);
        wdat[0] = 8'h3C;
        tx_write(15'h0000, 1, ok);
        wait_ready(polls);
        rd_random(15'h03FF, 2, ok);
        chk("R10 last location", rdat[0], 8'hC3);
        chk("R10 wrap to zero", rdat[1], 8'h3C);
        rd_current(1, ok);
        chk("R10 read ended, counter kept", rdat[0], model[10'h001]);

        // Random mix of writes and reads
        for (int it = 0; it < 10; it++) begin
            logic [14:0] ad = 15'($urandom);
            int n = 1 + ($urandom % 4);
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            tx_write(ad, n, ok);
            chk("R4 random write acked", ok, 1);
            wait_ready(polls);
            rd_random(ad, 1, ok);
            chk("R9 random readback", rdat[0], model[ad[AW-1:0]]);
            ea = page_step(ad[AW-1:0], 1);
            if (n > 1) begin
                rd_random({5'd0, ea}, 1, ok);
                chk("R5 random second byte", rdat[0], model[ea]);
            end
        end

        chk("R2 pull moved only with clock low", glitch, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule